// File: doc/BRIEF.md
# Variable-Length Instruction Byte Splitter

This block takes a stream of x86 instruction bytes, delivered as 64-bit fetch chunks, and cuts it into instructions. For each instruction it produces one record with these fields:

- the legacy prefixes folded into one flag byte
- the REX byte
- a flag for the two-byte opcode map
- the opcode
- the ModRM and SIB bytes, each with a presence flag
- a displacement, sign-extended to 64 bits
- a zero-extended immediate
- the address of the instruction's first byte

A state machine consumes one byte per clock. When every byte of a chunk has been used, the block raises a request for more bytes and waits. A field that is only partly collected, such as a displacement cut by the chunk edge, carries on in the next chunk.

The fetch stage offers a chunk together with a starting byte offset and the chunk's base address. A chunk is taken only while the request is high. A finished record sits on the output with a ready flag until the consumer acknowledges it, and no bytes are consumed while a record is waiting. ModRM presence comes from computed one-byte and two-byte opcode maps. Immediate sizes cover only a small set of opcodes. Addressing is 32/64-bit only.

Top module: `insn_predecode`

## Requirements
- R1: After reset, `need_bytes_o` is 1 and `rec_ready_o` is 0.
- R2: A chunk is loaded only in a cycle where `need_bytes_o` is 1 and `chunk_valid_i` is 1; a chunk offered at any other time is ignored. Consumption starts at byte `chunk_off_i`, where byte k is `chunk_data_i[8k+7:8k]`. Once byte 7 has been consumed, `need_bytes_o` rises and stays high until the next chunk is loaded.
- R3: `rec_legacy_o` bits [2:0] hold the segment override code: 0x2E=1, 0x3E=2, 0x26=3, 0x64=4, 0x65=5, 0x36=6. The other prefixes set single bits: 0x66 bit 3, 0x67 bit 4, 0xF0 bit 5, 0xF3 bit 6, 0xF2 bit 7.
- R4: A later segment override replaces the earlier code. A repeated flag prefix leaves its bit set.
- R5: A REX byte (0x40–0x4F) is reported in `rec_rex_o`. A legacy prefix that follows it clears `rec_rex_o` to 0. Once a REX byte has been taken, the next non-legacy byte is the opcode, even if it lies in 0x40–0x4F.
- R6: A first opcode byte of 0x0F sets `rec_two_byte_o`, and the byte after it becomes `rec_opcode_o`.
- R7: `rec_has_modrm_o` follows the opcode maps. For example, one-byte 0x89, 0x8B and 0x81 take ModRM; one-byte 0x90, 0x47 and 0xB0 do not; two-byte 0xAF takes ModRM and two-byte 0x05 does not.
- R8: A SIB byte follows the ModRM byte when r/m (bits [2:0]) is 4 and mod (bits [7:6]) is not 3.
- R9: The displacement size is set as follows:
  - mod=1 gives 1 byte.
  - mod=2 gives 4 bytes.
  - mod=0 with r/m=5, or mod=0 with SIB base (bits [2:0]) of 5, gives 4 bytes.
  - Otherwise there is no displacement.

  The bytes are read little-endian and sign-extended to 64 bits.
- R10: Immediate sizes are 1 byte for one-byte opcodes 0xB0–0xB7, 0x80, 0x83 and 0x6A, and 4 bytes for 0xB8–0xBF, 0x81 and 0x68. The immediate is read little-endian and zero-extended.
- R11: A field cut by a chunk boundary is completed from the following chunk with no loss of bytes.
- R12: While `rec_ready_o` is 1 and `rec_ack_i` is 0, the record holds steady and no bytes are consumed. An acknowledge clears `rec_ready_o` on the next edge.
- R13: `rec_pc_o` equals the base address of the chunk holding the instruction's first byte plus that byte's index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chunk_valid_i | input | 1 | Fetch chunk offered |
| chunk_data_i | input | 64 | Chunk bytes, byte 0 in bits [7:0] |
| chunk_off_i | input | 3 | Index of first byte to use |
| chunk_pc_i | input | 64 | Address of chunk byte 0 |
| need_bytes_o | output | 1 | Requests a new chunk |
| rec_ready_o | output | 1 | Record valid |
| rec_ack_i | input | 1 | Consumer takes the record |
| rec_pc_o | output | 64 | Address of instruction's first byte |
| rec_legacy_o | output | 8 | Folded legacy prefix flags |
| rec_rex_o | output | 8 | REX byte, 0 if none |
| rec_two_byte_o | output | 1 | Two-byte opcode map |
| rec_opcode_o | output | 8 | Opcode byte |
| rec_has_modrm_o | output | 1 | ModRM present |
| rec_modrm_o | output | 8 | ModRM byte |
| rec_has_sib_o | output | 1 | SIB present |
| rec_sib_o | output | 8 | SIB byte |
| rec_disp_o | output | 64 | Sign-extended displacement |
| rec_imm_o | output | 64 | Zero-extended immediate |

## Verification
The bench targets these corner cases, and each one exposes a specific kind of defect:

- **Straddling instruction.** One instruction has its SIB byte, 32-bit displacement and 32-bit immediate spread across a chunk boundary, and its chunk starts at a nonzero offset. A design that restarts the field count, or reads the unused leading bytes, reports a wrong displacement, stray prefix flags or a wrong address.
- **REX handling.** A REX byte followed by a lock prefix, and a REX byte followed by another 0x4X byte, are checked. Getting these wrong leaves a stale REX value or turns the opcode into a second prefix.
- **Displacement encodings.** Negative 8-bit and 32-bit displacements, and the mod=0 base-5 forms, expose missing sign extension and displacement lengths that swallow the next instruction.
- **Held record.** A record is held unacknowledged while a stray chunk is offered. A design that keeps consuming, or accepts that chunk, loses or corrupts the following records.

// File: rtl/insn_pd_pkg.sv
package insn_pd_pkg;

  localparam int unsigned SZ_W = 3;

  typedef enum logic [2:0] {
    ST_PFX, ST_OPC, ST_MODRM, ST_SIB, ST_DISP, ST_IMM
  } pd_state_e;

  typedef struct packed {
    logic      done;
    pd_state_e st;
  } pd_route_t;

  // Next field after the current one, given pending displacement/immediate sizes.
  function automatic pd_route_t route(input logic [SZ_W-1:0] dsz, input logic [SZ_W-1:0] isz);
    pd_route_t r;
    r.done = (dsz == '0) && (isz == '0);
    r.st   = (dsz != '0) ? ST_DISP : (isz != '0) ? ST_IMM : ST_PFX;
    return r;
  endfunction

  // Row masks of the ModRM maps; bit n of the mask is low nibble n.
  function automatic logic modrm_used(input logic two, input logic [7:0] op);
    logic [15:0] m;
    if (!two) begin
      unique case (op[7:4])
        4'h0, 4'h1, 4'h2, 4'h3: m = 16'h0F0F;
        4'h6:                   m = 16'h0A0C;
        4'h8:                   m = 16'hFFFF;
        4'hC:                   m = 16'h00F3;
        4'hD:                   m = 16'hFF0F;
        4'hF:                   m = 16'hC0C0;
        default:                m = 16'h0000;
      endcase
    end else begin
      unique case (op[7:4])
        4'h0:                         m = 16'hA00F;
        4'h1:                         m = 16'h01FF;
        4'h2:                         m = 16'hFF5F;
        4'h4, 4'h5, 4'h6, 4'h9,
        4'hD, 4'hE:                   m = 16'hFFFF;
        4'h7:                         m = 16'hF07F;
        4'hA:                         m = 16'hF8F8;
        4'hB:                         m = 16'hFCFF;
        4'hC:                         m = 16'h00FF;
        4'hF:                         m = 16'h7FFF;
        default:                      m = 16'h0000;
      endcase
    end
    return m[op[3:0]];
  endfunction

  // Immediate size stub.
  function automatic logic [SZ_W-1:0] imm_bytes(input logic two, input logic [7:0] op);
    if (two) return '0;
    if (op[7:3] == 5'b10110) return SZ_W'(1);
    if (op[7:3] == 5'b10111) return SZ_W'(4);
    unique case (op)
      8'h80, 8'h83, 8'h6A: return SZ_W'(1);
      8'h81, 8'h68:        return SZ_W'(4);
      default:             return '0;
    endcase
  endfunction

endpackage

// File: rtl/pd_chunk_buf.sv
module pd_chunk_buf #(
  parameter int unsigned CHUNK_BYTES = 8,
  parameter int unsigned PC_W        = 64,
  localparam int unsigned OFF_W      = $clog2(CHUNK_BYTES),
  localparam int unsigned CHUNK_W    = CHUNK_BYTES * 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [CHUNK_W-1:0] data_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic               take_i,
  output logic               need_o,
  output logic [7:0]         byte_o,
  output logic [PC_W-1:0]    byte_pc_o
);
  logic [CHUNK_W-1:0] data_q;
  logic [OFF_W-1:0]   off_q;
  logic [PC_W-1:0]    base_q;
  logic               need_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      off_q  <= '0;
      base_q <= '0;
      need_q <= 1'b1;
    end else if (need_q) begin
      if (load_i) begin
        data_q <= data_i;
        off_q  <= off_i;
        base_q <= pc_i;
        need_q <= 1'b0;
      end
    end else if (take_i) begin
      off_q <= off_q + OFF_W'(1);
      if (off_q == OFF_W'(CHUNK_BYTES - 1)) need_q <= 1'b1;
    end
  end

  always_comb begin
    byte_o = '0;
    for (int k = 0; k < CHUNK_BYTES; k++)
      if (off_q == OFF_W'(k)) byte_o = data_q[k*8 +: 8];
  end

  assign need_o    = need_q;
  assign byte_pc_o = base_q + PC_W'(off_q);
endmodule

// File: rtl/pd_pfx_class.sv
module pd_pfx_class (
  input  logic [7:0] byte_i,
  output logic       legacy_o,
  output logic       seg_o,
  output logic [2:0] seg_code_o,
  output logic [4:0] flag_o,
  output logic       rex_o
);
  always_comb begin
    seg_o      = 1'b1;
    seg_code_o = 3'd0;
    flag_o     = 5'b0;
    unique case (byte_i)
      8'h2E: seg_code_o = 3'd1;
      8'h3E: seg_code_o = 3'd2;
      8'h26: seg_code_o = 3'd3;
      8'h64: seg_code_o = 3'd4;
      8'h65: seg_code_o = 3'd5;
      8'h36: seg_code_o = 3'd6;
      default: seg_o = 1'b0;
    endcase
    unique case (byte_i)
      8'h66: flag_o = 5'b00001;
      8'h67: flag_o = 5'b00010;
      8'hF0: flag_o = 5'b00100;
      8'hF3: flag_o = 5'b01000;
      8'hF2: flag_o = 5'b10000;
      default: flag_o = 5'b0;
    endcase
  end

  assign legacy_o = seg_o || (flag_o != '0);
  assign rex_o    = (byte_i[7:4] == 4'h4);
endmodule

// File: rtl/pd_field_acc.sv
module pd_field_acc #(
  parameter int unsigned MAX_BYTES = 4,
  parameter bit          SIGNED    = 1'b1,
  parameter int unsigned VAL_W     = 64,
  localparam int unsigned SZ_W     = 3,
  localparam int unsigned BUF_W    = MAX_BYTES * 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [7:0]       byte_i,
  input  logic [SZ_W-1:0]  size_i,
  output logic             last_o,
  output logic [VAL_W-1:0] val_o
);
  logic [BUF_W-1:0] buf_q;
  logic [SZ_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= cnt_q + SZ_W'(1);
    end
  end

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   buf_q[g*8 +: 8] <= '0;
      else if (clr_i)                                buf_q[g*8 +: 8] <= '0;
      else if (load_i && cnt_q == SZ_W'(g))          buf_q[g*8 +: 8] <= byte_i;
    end
  end

  assign last_o = load_i && ((cnt_q + SZ_W'(1)) == size_i);

  if (SIGNED) begin : g_sext
    always_comb begin
      val_o = VAL_W'(buf_q);
      for (int k = 1; k <= MAX_BYTES; k++)
        if (size_i == SZ_W'(k) && buf_q[k*8-1])
          val_o = VAL_W'(buf_q) | ({VAL_W{1'b1}} << (k*8));
    end
  end else begin : g_zext
    assign val_o = VAL_W'(buf_q);
  end
endmodule

// File: rtl/insn_predecode.sv
module insn_predecode
  import insn_pd_pkg::*;
#(
  parameter int unsigned CHUNK_BYTES = 8,
  parameter int unsigned PC_W        = 64,
  parameter int unsigned DISP_BYTES  = 4,
  parameter int unsigned IMM_BYTES   = 4,
  parameter int unsigned VAL_W       = 64,
  localparam int unsigned OFF_W      = $clog2(CHUNK_BYTES),
  localparam int unsigned CHUNK_W    = CHUNK_BYTES * 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               chunk_valid_i,
  input  logic [CHUNK_W-1:0] chunk_data_i,
  input  logic [OFF_W-1:0]   chunk_off_i,
  input  logic [PC_W-1:0]    chunk_pc_i,
  output logic               need_bytes_o,
  output logic               rec_ready_o,
  input  logic               rec_ack_i,
  output logic [PC_W-1:0]    rec_pc_o,
  output logic [7:0]         rec_legacy_o,
  output logic [7:0]         rec_rex_o,
  output logic               rec_two_byte_o,
  output logic [7:0]         rec_opcode_o,
  output logic               rec_has_modrm_o,
  output logic [7:0]         rec_modrm_o,
  output logic               rec_has_sib_o,
  output logic [7:0]         rec_sib_o,
  output logic [VAL_W-1:0]   rec_disp_o,
  output logic [VAL_W-1:0]   rec_imm_o
);
  pd_state_e       st_q;
  logic            ready_q, start_q, rex_seen_q;
  logic [PC_W-1:0] pc_q;
  logic [7:0]      legacy_q, rex_q, opc_q, modrm_q, sib_q;
  logic            two_q, has_modrm_q, has_sib_q;
  logic [SZ_W-1:0] dsize_q, isize_q;

  logic            need, take, ack_fire;
  logic [7:0]      b;
  logic [PC_W-1:0] b_pc;

  assign ack_fire = ready_q && rec_ack_i;
  assign take     = !need && !ready_q;

  pd_chunk_buf #(.CHUNK_BYTES(CHUNK_BYTES), .PC_W(PC_W)) u_buf (
    .clk_i, .rst_ni,
    .load_i(chunk_valid_i), .data_i(chunk_data_i), .off_i(chunk_off_i), .pc_i(chunk_pc_i),
    .take_i(take), .need_o(need), .byte_o(b), .byte_pc_o(b_pc)
  );

  logic       p_leg, p_seg, p_rex;
  logic [2:0] p_seg_code;
  logic [4:0] p_flag;
  pd_pfx_class u_pfx (
    .byte_i(b), .legacy_o(p_leg), .seg_o(p_seg), .seg_code_o(p_seg_code),
    .flag_o(p_flag), .rex_o(p_rex)
  );

  logic disp_last, imm_last;
  pd_field_acc #(.MAX_BYTES(DISP_BYTES), .SIGNED(1'b1), .VAL_W(VAL_W)) u_disp (
    .clk_i, .rst_ni, .clr_i(ack_fire), .load_i(take && st_q == ST_DISP),
    .byte_i(b), .size_i(dsize_q), .last_o(disp_last), .val_o(rec_disp_o)
  );
  pd_field_acc #(.MAX_BYTES(IMM_BYTES), .SIGNED(1'b0), .VAL_W(VAL_W)) u_imm (
    .clk_i, .rst_ni, .clr_i(ack_fire), .load_i(take && st_q == ST_IMM),
    .byte_i(b), .size_i(isize_q), .last_o(imm_last), .val_o(rec_imm_o)
  );

  // Per-byte decode terms
  logic            pfx_take, opc_mod;
  logic [SZ_W-1:0] opc_isz, m_dsz, s_dsz;
  logic            m_sib;
  pd_route_t       r_opc, r_modrm, r_sib, r_disp;

  always_comb begin
    pfx_take = p_leg || (p_rex && !rex_seen_q);
    opc_mod  = modrm_used(st_q == ST_OPC, b);
    opc_isz  = imm_bytes(st_q == ST_OPC, b);
    m_sib    = (b[2:0] == 3'd4) && (b[7:6] != 2'd3);
    unique case (b[7:6])
      2'd1:    m_dsz = SZ_W'(1);
      2'd2:    m_dsz = SZ_W'(4);
      2'd0:    m_dsz = (b[2:0] == 3'd5) ? SZ_W'(4) : '0;
      default: m_dsz = '0;
    endcase
    s_dsz   = (modrm_q[7:6] == 2'd0 && b[2:0] == 3'd5) ? SZ_W'(4) : dsize_q;
    r_opc   = route('0, opc_isz);
    r_modrm = route(m_dsz, isize_q);
    r_sib   = route(s_dsz, isize_q);
    r_disp  = route('0, isize_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_PFX; ready_q <= 1'b0; start_q <= 1'b1; rex_seen_q <= 1'b0;
      pc_q <= '0; legacy_q <= '0; rex_q <= '0; opc_q <= '0; modrm_q <= '0; sib_q <= '0;
      two_q <= 1'b0; has_modrm_q <= 1'b0; has_sib_q <= 1'b0; dsize_q <= '0; isize_q <= '0;
    end else if (ack_fire) begin
      ready_q <= 1'b0; start_q <= 1'b1; rex_seen_q <= 1'b0;
      legacy_q <= '0; rex_q <= '0; opc_q <= '0; modrm_q <= '0; sib_q <= '0;
      two_q <= 1'b0; has_modrm_q <= 1'b0; has_sib_q <= 1'b0; dsize_q <= '0; isize_q <= '0;
    end else if (take) begin
      if (start_q) begin
        pc_q    <= b_pc;
        start_q <= 1'b0;
      end
      if (st_q == ST_PFX && pfx_take) begin
        if (p_leg) begin
          if (p_seg) legacy_q[2:0] <= p_seg_code;
          legacy_q[7:3] <= legacy_q[7:3] | p_flag;
          rex_q      <= '0;
          rex_seen_q <= 1'b0;
        end else begin
          rex_q      <= b;
          rex_seen_q <= 1'b1;
        end
      end else if (st_q == ST_PFX && b == 8'h0F) begin
        two_q <= 1'b1;
        st_q  <= ST_OPC;
      end else if (st_q == ST_PFX || st_q == ST_OPC) begin
        opc_q   <= b;
        isize_q <= opc_isz;
        if (opc_mod) begin
          has_modrm_q <= 1'b1;
          st_q        <= ST_MODRM;
        end else begin
          st_q    <= r_opc.st;
          ready_q <= r_opc.done;
        end
      end else begin
        unique case (st_q)
          ST_MODRM: begin
            modrm_q <= b;
            dsize_q <= m_dsz;
            if (m_sib) st_q <= ST_SIB;
            else begin
              st_q    <= r_modrm.st;
              ready_q <= r_modrm.done;
            end
          end
          ST_SIB: begin
            sib_q     <= b;
            has_sib_q <= 1'b1;
            dsize_q   <= s_dsz;
            st_q      <= r_sib.st;
            ready_q   <= r_sib.done;
          end
          ST_DISP: if (disp_last) begin
            st_q    <= r_disp.st;
            ready_q <= r_disp.done;
          end
          ST_IMM: if (imm_last) begin
            st_q    <= ST_PFX;
            ready_q <= 1'b1;
          end
          default: st_q <= ST_PFX;
        endcase
      end
    end
  end

  assign need_bytes_o    = need;
  assign rec_ready_o     = ready_q;
  assign rec_pc_o        = pc_q;
  assign rec_legacy_o    = legacy_q;
  assign rec_rex_o       = rex_q;
  assign rec_two_byte_o  = two_q;
  assign rec_opcode_o    = opc_q;
  assign rec_has_modrm_o = has_modrm_q;
  assign rec_modrm_o     = modrm_q;
  assign rec_has_sib_o   = has_sib_q;
  assign rec_sib_o       = sib_q;
endmodule

// File: rtl/insn_predecode_chk.sv
module insn_predecode_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        chunk_valid_i,
  input logic        need_bytes_o,
  input logic        rec_ready_o,
  input logic        rec_ack_i,
  input logic [63:0] rec_pc_o,
  input logic [7:0]  rec_legacy_o,
  input logic [7:0]  rec_rex_o,
  input logic [7:0]  rec_opcode_o,
  input logic        rec_has_modrm_o,
  input logic [7:0]  rec_modrm_o,
  input logic        rec_has_sib_o,
  input logic [63:0] rec_disp_o,
  input logic [63:0] rec_imm_o
);
  a_r12_record_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_ready_o && !rec_ack_i |=> rec_ready_o && $stable(rec_opcode_o) && $stable(rec_pc_o));

  a_r12_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_ready_o && rec_ack_i |=> !rec_ready_o);

  a_r2_wait_for_chunk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    need_bytes_o && !chunk_valid_i |=> need_bytes_o);

  a_r2_chunk_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    need_bytes_o && chunk_valid_i |=> !need_bytes_o);

  a_r3_seg_code_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_ready_o |-> rec_legacy_o[2:0] != 3'd7);

  a_r9_disp_sext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_ready_o |-> (&rec_disp_o[63:31]) || !(|rec_disp_o[63:31]));

  a_r10_imm_zext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_ready_o |-> rec_imm_o[63:32] == 32'd0);

  a_r5_rex_form: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_ready_o && rec_rex_o != 8'd0 |-> rec_rex_o[7:4] == 4'h4);

  a_r8_sib_rule: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_ready_o && rec_has_sib_o |-> rec_has_modrm_o && rec_modrm_o[2:0] == 3'd4 && rec_modrm_o[7:6] != 2'd3);
endmodule

bind insn_predecode insn_predecode_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .chunk_valid_i(chunk_valid_i),
  .need_bytes_o(need_bytes_o), .rec_ready_o(rec_ready_o), .rec_ack_i(rec_ack_i),
  .rec_pc_o(rec_pc_o), .rec_legacy_o(rec_legacy_o), .rec_rex_o(rec_rex_o),
  .rec_opcode_o(rec_opcode_o), .rec_has_modrm_o(rec_has_modrm_o), .rec_modrm_o(rec_modrm_o),
  .rec_has_sib_o(rec_has_sib_o), .rec_disp_o(rec_disp_o), .rec_imm_o(rec_imm_o)
);

// File: tb/insn_predecode_tb_top.sv
module insn_predecode_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chunk_valid = 1'b0;
  logic [63:0] chunk_data = '0;
  logic [2:0]  chunk_off = '0;
  logic [63:0] chunk_pc = '0;
  logic        need_o, ready_o, ack;
  logic [63:0] pc_o, disp_o, imm_o;
  logic [7:0]  leg_o, rex_o, op_o, modrm_o, sib_o;
  logic        two_o, hm_o, hs_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  insn_predecode dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .chunk_valid_i(chunk_valid), .chunk_data_i(chunk_data), .chunk_off_i(chunk_off), .chunk_pc_i(chunk_pc),
    .need_bytes_o(need_o), .rec_ready_o(ready_o), .rec_ack_i(ack),
    .rec_pc_o(pc_o), .rec_legacy_o(leg_o), .rec_rex_o(rex_o), .rec_two_byte_o(two_o),
    .rec_opcode_o(op_o), .rec_has_modrm_o(hm_o), .rec_modrm_o(modrm_o),
    .rec_has_sib_o(hs_o), .rec_sib_o(sib_o), .rec_disp_o(disp_o), .rec_imm_o(imm_o)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit hold_ack = 1'b0;
  bit ended = 1'b0;

  int          rec_cnt = 0;
  logic [63:0] r_pc[64], r_disp[64], r_imm[64];
  logic [7:0]  r_leg[64], r_rex[64], r_op[64], r_m[64], r_s[64];
  logic        r_two[64], r_hm[64], r_hs[64];

  // Record collector with automatic acknowledge
  initial ack = 1'b0;
  always @(negedge clk) begin
    if (ack) ack = 1'b0;
    else if (rst_n && ready_o && !hold_ack && rec_cnt < 64) begin
      r_pc[rec_cnt] = pc_o;   r_leg[rec_cnt] = leg_o; r_rex[rec_cnt] = rex_o;
      r_two[rec_cnt] = two_o; r_op[rec_cnt] = op_o;   r_hm[rec_cnt] = hm_o;
      r_m[rec_cnt] = modrm_o; r_hs[rec_cnt] = hs_o;   r_s[rec_cnt] = sib_o;
      r_disp[rec_cnt] = disp_o; r_imm[rec_cnt] = imm_o;
      rec_cnt = rec_cnt + 1;
      ack = 1'b1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !ended) begin
      ended = 1'b1;
      fails = fails + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic feed(input logic [63:0] data, input logic [2:0] off, input logic [63:0] pc);
    while (!need_o) @(negedge clk);
    chunk_data = data; chunk_off = off; chunk_pc = pc; chunk_valid = 1'b1;
    @(negedge clk);
    chunk_valid = 1'b0;
  endtask

  task automatic settle();
    do @(negedge clk); while (!(need_o && !ready_o));
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "need after reset", 64'(need_o), 64'd1);
    chk("R1", "ready after reset", 64'(ready_o), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_prefixes();
    int b0 = rec_cnt;
    feed(64'h90909090_F33E2E66, 3'd0, 64'h1000);
    settle();
    chk("R2", "record count", 64'(rec_cnt - b0), 64'd4);
    chk("R3", "legacy fold", 64'(r_leg[b0]), 64'h4A);
    chk("R4", "segment last wins", 64'(r_leg[b0][2:0]), 64'd2);
    chk("R13", "pc first", r_pc[b0], 64'h1000);
    chk("R7", "0x90 no modrm", 64'(r_hm[b0]), 64'd0);
    chk("R13", "pc last", r_pc[b0+3], 64'h1007);
    chk("R3", "no carry of flags", 64'(r_leg[b0+1]), 64'd0);
  endtask

  task automatic t_rex();
    int b0 = rec_cnt;
    feed(64'h474190F0_48D88948, 3'd0, 64'h2000);
    settle();
    chk("R5", "record count", 64'(rec_cnt - b0), 64'd3);
    chk("R5", "rex kept", 64'(r_rex[b0]), 64'h48);
    chk("R7", "0x89 modrm", 64'(r_hm[b0]), 64'd1);
    chk("R8", "mod3 no sib", 64'(r_hs[b0]), 64'd0);
    chk("R9", "mod3 no disp", r_disp[b0], 64'd0);
    chk("R5", "rex cleared by lock", 64'(r_rex[b0+1]), 64'd0);
    chk("R3", "lock bit", 64'(r_leg[b0+1]), 64'h20);
    chk("R5", "4x after rex is opcode", 64'(r_op[b0+2]), 64'h47);
    chk("R5", "rex before 4x opcode", 64'(r_rex[b0+2]), 64'h41);
    chk("R13", "pc rex insn", r_pc[b0+2], 64'h2006);
  endtask

  task automatic t_two_byte();
    int b0 = rec_cnt;
    feed(64'h90050FF0_2444AF0F, 3'd0, 64'h3000);
    settle();
    chk("R6", "record count", 64'(rec_cnt - b0), 64'd3);
    chk("R6", "two-byte flag", 64'(r_two[b0]), 64'd1);
    chk("R6", "second opcode", 64'(r_op[b0]), 64'hAF);
    chk("R8", "sib present", 64'(r_hs[b0]), 64'd1);
    chk("R8", "sib byte", 64'(r_s[b0]), 64'h24);
    chk("R9", "disp8 negative", r_disp[b0], 64'hFFFF_FFFF_FFFF_FFF0);
    chk("R7", "two-byte 05 no modrm", 64'(r_hm[b0+1]), 64'd0);
    chk("R6", "two-byte 05 opcode", 64'(r_op[b0+1]), 64'h05);
    chk("R6", "flag cleared next", 64'(r_two[b0+2]), 64'd0);
  endtask

  task automatic t_straddle();
    int b0 = rec_cnt;
    feed(64'h5678C884_81666666, 3'd3, 64'h4000);
    while (!need_o) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R2", "stalled waiting for chunk", 64'(need_o), 64'd1);
    chk("R11", "no partial record", 64'(rec_cnt - b0), 64'd0);
    feed(64'h9090DEAD_BEEF1234, 3'd0, 64'h4008);
    settle();
    chk("R11", "record count", 64'(rec_cnt - b0), 64'd3);
    chk("R2", "skipped leading bytes", 64'(r_leg[b0]), 64'd0);
    chk("R13", "pc at offset", r_pc[b0], 64'h4003);
    chk("R11", "disp32 across chunks", r_disp[b0], 64'h0000_0000_1234_5678);
    chk("R10", "imm32 across chunks", r_imm[b0], 64'h0000_0000_DEAD_BEEF);
    chk("R8", "sib base 0", 64'(r_s[b0]), 64'hC8);
    chk("R13", "pc after straddle", r_pc[b0+1], 64'h400E);
  endtask

  task automatic t_disp_forms();
    int b0 = rec_cnt;
    feed(64'h7FB08000_0000058B, 3'd0, 64'h5000);
    feed(64'h90FFFFFF_FE25048B, 3'd0, 64'h5008);
    settle();
    chk("R9", "record count", 64'(rec_cnt - b0), 64'd4);
    chk("R9", "mod0 rm5 disp32", r_disp[b0], 64'hFFFF_FFFF_8000_0000);
    chk("R8", "rm5 no sib", 64'(r_hs[b0]), 64'd0);
    chk("R10", "imm8 B0", r_imm[b0+1], 64'h7F);
    chk("R7", "B0 no modrm", 64'(r_hm[b0+1]), 64'd0);
    chk("R9", "sib base5 disp32", r_disp[b0+2], 64'hFFFF_FFFF_FFFF_FFFE);
    chk("R13", "pc sib insn", r_pc[b0+2], 64'h5008);
    chk("R9", "disp cleared next", r_disp[b0+3], 64'd0);
  endtask

  task automatic t_hold();
    int b0 = rec_cnt;
    bit all_nop = 1'b1;
    hold_ack = 1'b1;
    feed(64'h90909090_90909090, 3'd0, 64'h6000);
    while (!ready_o) @(negedge clk);
    repeat (5) @(negedge clk);
    chk("R12", "ready held", 64'(ready_o), 64'd1);
    chk("R12", "pc held", pc_o, 64'h6000);
    chk("R12", "consumption paused", 64'(need_o), 64'd0);
    chunk_data = 64'h0F0F0F0F_0F0F0F0F; chunk_valid = 1'b1;
    @(negedge clk);
    chunk_valid = 1'b0;
    hold_ack = 1'b0;
    settle();
    chk("R12", "record count", 64'(rec_cnt - b0), 64'd8);
    for (int i = 0; i < 8; i++) if (r_op[b0+i] !== 8'h90) all_nop = 1'b0;
    chk("R2", "busy chunk ignored", 64'(all_nop), 64'd1);
    chk("R13", "pc last", r_pc[b0+7], 64'h6007);
  endtask

  initial begin
    t_reset();
    t_prefixes();
    t_rex();
    t_two_byte();
    t_straddle();
    t_disp_forms();
    t_hold();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule